// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block connects two 18-bit buses, called the A side and the B side, through two independent one-way paths: one carries A data towards B and the other carries B data towards A. Each path holds one storage cell. A control input picks how the cell behaves. When the pass input is high the cell is a transparent latch. When pass is low the cell is a register that loads on a falling edge of its own strobe input, and only if the active-low strobe enable is low. When pass is low and no such edge occurs, the cell holds its value. Data is never inverted.

Each path drives the far bus through a per-bit output-enable vector, and an active-low drive control sets that vector. The bus pins are modelled as separate input, output and output-enable vectors, which keeps the design synthesizable. The surrounding pad logic builds the real tri-state pins. All logic runs on a single system clock. The strobe inputs are sampled on that clock, so a falling strobe edge is seen as a high sample followed by a low sample. An active-high synchronous reset clears both cells and releases both buses.

Top module: `univ_xcvr`

## Requirements
- R1: While a path's pass input is high, its output data equals its input data bit for bit in the same cycle, with no inversion.
- R2: While pass is low and the strobe stays steady (high or low), the output data keeps its stored value whatever the input does.
- R3: While pass is low, a strobe sampled high in one clock cycle and low in the next, with strobe enable low, loads that cycle's input data. The value shows at the output after that clock edge.
- R4: A falling strobe edge while the strobe enable is high loads nothing.
- R5: A rising strobe edge loads nothing.
- R6: When pass goes low, the output keeps the last value that was passed through.
- R7: Drive control low sets every bit of the path's output-enable vector to 1. Drive control high sets every bit to 0, which releases the bus. The output data stays valid either way.
- R8: The A-to-B and B-to-A paths are independent. Activity on one path never changes the other path's output data or enable.
- R9: While reset is high, both output-enable vectors are all zero. After reset, both cells hold zero.
- R10: A strobe that was high during reset and is low in the first cycle after reset is not a falling edge and loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data received from the A bus |
| a_out | output | 18 | Data to drive onto the A bus |
| a_oe | output | 18 | Per-bit drive enable for the A bus |
| b_in | input | 18 | Data received from the B bus |
| b_out | output | 18 | Data to drive onto the B bus |
| b_oe | output | 18 | Per-bit drive enable for the B bus |
| ab_pass | input | 1 | A-to-B transparent select |
| ab_strobe | input | 1 | A-to-B load strobe, falling edge active |
| ab_strobe_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_drive_n | input | 1 | B-bus drive control, active low |
| ba_pass | input | 1 | B-to-A transparent select |
| ba_strobe | input | 1 | B-to-A load strobe, falling edge active |
| ba_strobe_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_drive_n | input | 1 | A-bus drive control, active low |

## Verification
The bench drives a strobe through rise, steady high, a disabled fall and an enabled fall. A design that loads on the wrong edge, or that ignores the enable, shows a changed value where the bench expects the old one. It drops pass and checks that the last passed-through value is held, which catches a cell that only stores on strobes. It raises the strobe during reset and lowers it at release to catch an edge detector that keeps sampling through reset. It also runs one path while the other holds, to catch crossed or shared controls.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_DEF_WIDTH = 18;
    localparam int unsigned XCVR_NDIR      = 2;

    // control bundle for one direction
    typedef struct packed {
        logic pass;
        logic strobe;
        logic strobe_en_n;
        logic drive_n;
    } path_ctl_t;

    // what the storage cell does this cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_TRACK = 2'd1,
        OP_LOAD  = 2'd2
    } cell_op_t;

    // transparent select has priority over an enabled falling strobe
    function automatic cell_op_t pick_op(input logic pass,
                                         input logic fell,
                                         input logic strobe_en_n);
        cell_op_t op;
        if (pass)
            op = OP_TRACK;
        else if (fell && !strobe_en_n)
            op = OP_LOAD;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fell
);
    logic strobe_q;

    // previous sample cleared in reset, so a strobe held high through reset
    // is not taken for a falling edge at release
    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= 1'b0;
        else
            strobe_q <= strobe;
    end

    assign fell = strobe_q & ~strobe;

endmodule

// File: rtl/xcvr_cell.sv
module xcvr_cell
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  cell_op_t         op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else begin
            unique case (op)
                OP_TRACK: held_q <= din;
                OP_LOAD:  held_q <= din;
                default:  held_q <= held_q;
            endcase
        end
    end

    // live input shown while transparent, stored word otherwise
    assign dout = (op == OP_TRACK) ? din : held_q;

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_DEF_WIDTH
) (
    input  logic             rst,
    input  logic             drive_n,
    output logic [WIDTH-1:0] oe
);
    logic drive_on;

    assign drive_on = ~drive_n & ~rst;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign oe[i] = drive_on;
    end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  path_ctl_t        ctl,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst,
    output logic [WIDTH-1:0] dst_oe
);
    logic     fell;
    cell_op_t op;

    xcvr_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctl.strobe),
        .fell   (fell)
    );

    assign op = pick_op(ctl.pass, fell, ctl.strobe_en_n);

    xcvr_cell #(.WIDTH(WIDTH)) u_cell (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .din  (src),
        .dout (dst)
    );

    xcvr_drive #(.WIDTH(WIDTH)) u_drive (
        .rst     (rst),
        .drive_n (ctl.drive_n),
        .oe      (dst_oe)
    );

endmodule

// File: rtl/univ_xcvr.sv
module univ_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             ab_pass,
    input  logic             ab_strobe,
    input  logic             ab_strobe_en_n,
    input  logic             ab_drive_n,
    input  logic             ba_pass,
    input  logic             ba_strobe,
    input  logic             ba_strobe_en_n,
    input  logic             ba_drive_n
);
    localparam int unsigned NDIR = XCVR_NDIR;

    // index 0: A towards B, index 1: B towards A
    path_ctl_t        ctl_w [NDIR];
    logic [WIDTH-1:0] src_w [NDIR];
    logic [WIDTH-1:0] dst_w [NDIR];
    logic [WIDTH-1:0] oe_w  [NDIR];

    assign ctl_w[0] = '{pass: ab_pass, strobe: ab_strobe,
                        strobe_en_n: ab_strobe_en_n, drive_n: ab_drive_n};
    assign ctl_w[1] = '{pass: ba_pass, strobe: ba_strobe,
                        strobe_en_n: ba_strobe_en_n, drive_n: ba_drive_n};
    assign src_w[0] = a_in;
    assign src_w[1] = b_in;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        xcvr_path #(.WIDTH(WIDTH)) u_path (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl_w[d]),
            .src    (src_w[d]),
            .dst    (dst_w[d]),
            .dst_oe (oe_w[d])
        );
    end

    assign b_out = dst_w[0];
    assign b_oe  = oe_w[0];
    assign a_out = dst_w[1];
    assign a_oe  = oe_w[1];

endmodule

// File: rtl/univ_xcvr_chk.sv
module univ_xcvr_chk #(
    parameter int unsigned WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] b_oe,
    input logic             ab_pass,
    input logic             ab_strobe,
    input logic             ab_strobe_en_n,
    input logic             ab_drive_n,
    input logic             ba_pass,
    input logic             ba_strobe,
    input logic             ba_strobe_en_n,
    input logic             ba_drive_n
);
    logic [WIDTH-1:0] i_v   [2];
    logic [WIDTH-1:0] o_v   [2];
    logic [WIDTH-1:0] oe_v  [2];
    logic             pass_v[2];
    logic             stb_v [2];
    logic             en_n_v[2];
    logic             drv_n_v[2];

    assign i_v[0] = a_in;   assign i_v[1] = b_in;
    assign o_v[0] = b_out;  assign o_v[1] = a_out;
    assign oe_v[0] = b_oe;  assign oe_v[1] = a_oe;
    assign pass_v[0] = ab_pass;          assign pass_v[1] = ba_pass;
    assign stb_v[0] = ab_strobe;         assign stb_v[1] = ba_strobe;
    assign en_n_v[0] = ab_strobe_en_n;   assign en_n_v[1] = ba_strobe_en_n;
    assign drv_n_v[0] = ab_drive_n;      assign drv_n_v[1] = ba_drive_n;

    for (genvar d = 0; d < 2; d++) begin : g_chk
        // R1
        pass_follow_chk: assert property (@(posedge clk) disable iff (rst)
            pass_v[d] |-> (o_v[d] == i_v[d]));

        // R3
        load_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
            (!pass_v[d] && !en_n_v[d] && !$past(rst) && $past(stb_v[d]) && !stb_v[d])
            |=> (!pass_v[d] |-> (o_v[d] == $past(i_v[d]))));

        // R2
        hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!pass_v[d] && !(!en_n_v[d] && !$past(rst) && $past(stb_v[d]) && !stb_v[d]))
            |=> (!pass_v[d] |-> $stable(o_v[d])));

        // R7
        drive_on_chk: assert property (@(posedge clk) disable iff (rst)
            !drv_n_v[d] |-> (oe_v[d] == {WIDTH{1'b1}}));

        // R7
        drive_off_chk: assert property (@(posedge clk) disable iff (rst)
            drv_n_v[d] |-> (oe_v[d] == '0));

        // R9
        reset_release_chk: assert property (@(posedge clk)
            rst |-> (oe_v[d] == '0));
    end

endmodule

bind univ_xcvr univ_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .a_in           (a_in),
    .a_out          (a_out),
    .a_oe           (a_oe),
    .b_in           (b_in),
    .b_out          (b_out),
    .b_oe           (b_oe),
    .ab_pass        (ab_pass),
    .ab_strobe      (ab_strobe),
    .ab_strobe_en_n (ab_strobe_en_n),
    .ab_drive_n     (ab_drive_n),
    .ba_pass        (ba_pass),
    .ba_strobe      (ba_strobe),
    .ba_strobe_en_n (ba_strobe_en_n),
    .ba_drive_n     (ba_drive_n)
);

// File: tb/univ_xcvr_tb.sv
module univ_xcvr_tb;
    localparam int W  = 18;
    localparam int NV = 13;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
    logic         ab_pass, ab_strobe, ab_strobe_en_n, ab_drive_n;
    logic         ba_pass, ba_strobe, ba_strobe_en_n, ba_drive_n;

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    univ_xcvr #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_pass(ab_pass), .ab_strobe(ab_strobe),
        .ab_strobe_en_n(ab_strobe_en_n), .ab_drive_n(ab_drive_n),
        .ba_pass(ba_pass), .ba_strobe(ba_strobe),
        .ba_strobe_en_n(ba_strobe_en_n), .ba_drive_n(ba_drive_n)
    );

    // {pass, strobe, strobe_en_n, drive_n, a_in, expected b_out, b_oe all ones}
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 18'h12345, 18'h12345, 1'b1}, // R1 transparent
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h00AAA, 18'h12345, 1'b1}, // R6 last passed value
        {1'b0, 1'b1, 1'b0, 1'b0, 18'h00BBB, 18'h12345, 1'b1}, // R5 rising edge
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h0CCCC, 18'h0CCCC, 1'b1}, // R3 falling edge
        {1'b0, 1'b1, 1'b0, 1'b0, 18'h01111, 18'h0CCCC, 1'b1}, // R5 rising edge
        {1'b0, 1'b1, 1'b0, 1'b0, 18'h02222, 18'h0CCCC, 1'b1}, // R2 steady high
        {1'b0, 1'b0, 1'b1, 1'b0, 18'h03333, 18'h0CCCC, 1'b1}, // R4 disabled fall
        {1'b0, 1'b1, 1'b0, 1'b0, 18'h03333, 18'h0CCCC, 1'b1}, // R2 hold
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h3FFFF, 1'b1}, // R3 enabled fall
        {1'b0, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h3FFFF, 1'b0}, // R7 released, R2 hold
        {1'b1, 1'b0, 1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA, 1'b1}, // R1 transparent
        {1'b1, 1'b1, 1'b0, 1'b0, 18'h00F0F, 18'h00F0F, 1'b1}, // R1 transparent
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h15555, 18'h15555, 1'b1}  // R3 fall as pass drops
    };

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                         input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    // inputs settle at the falling clock edge; outputs sampled 1 ns after rise
    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0;
        ab_pass = 0; ab_strobe = 0; ab_strobe_en_n = 0; ab_drive_n = 0;
        ba_pass = 0; ba_strobe = 0; ba_strobe_en_n = 0; ba_drive_n = 1;
        cycle(); cycle();
        // R9 enables released during reset even with drive requested
        check(b_oe, '0, "R9 b_oe in reset");
        @(negedge clk) rst = 1'b0;
        cycle();
        check(b_out, '0, "R9 cleared cell");
        check(a_oe, '0, "R7 a side released");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ab_pass        = VEC[i][40];
            ab_strobe      = VEC[i][39];
            ab_strobe_en_n = VEC[i][38];
            ab_drive_n     = VEC[i][37];
            a_in           = VEC[i][36:19];
            cycle();
            check(b_out, VEC[i][18:1], $sformatf("R3 table row %0d data", i));
            check(b_oe, VEC[i][0] ? ONES : '0, $sformatf("R7 table row %0d enable", i));
        end

        // R8 B-to-A load while A-to-B holds 15555 and A input churns
        @(negedge clk);
        ba_drive_n = 0; ba_strobe = 1; b_in = 18'h01010; a_in = 18'h3C3C3;
        cycle();
        @(negedge clk);
        ba_strobe = 0; b_in = 18'h2BEEF; a_in = 18'h00001;
        cycle();
        check(a_out, 18'h2BEEF, "R8 B-to-A capture");
        check(a_oe, ONES, "R8 A side driven");
        check(b_out, 18'h15555, "R8 A-to-B untouched");
        @(negedge clk);
        ba_pass = 1; b_in = 18'h01234;
        cycle();
        check(a_out, 18'h01234, "R1 B-to-A transparent");
        check(b_out, 18'h15555, "R8 A-to-B still held");

        // R10 strobes high through reset, low at release: no load
        @(negedge clk);
        rst = 1; ab_strobe = 1; ba_strobe = 1; ba_pass = 0;
        ab_drive_n = 0; ba_drive_n = 0;
        cycle();
        check(a_oe, '0, "R9 a_oe in reset");
        check(b_oe, '0, "R9 b_oe in reset");
        @(negedge clk);
        rst = 0; ab_strobe = 0; ba_strobe = 0;
        a_in = 18'h2F0F0; b_in = 18'h30F0F;
        cycle();
        check(b_out, '0, "R10 no A-to-B load at release");
        check(a_out, '0, "R10 no B-to-A load at release");
        cycle();
        check(b_out, '0, "R2 hold after reset");
        check(b_oe, ONES, "R7 driven after reset");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule